// File: doc/BRIEF.md
# Scanline Sync and NMI Generator

This block keeps a horizontal position counter in step with the CPU's bus cycles and, from that count, produces the horizontal sync level for each scanline. Each completed bus cycle reports its length in clock cycles, and the counter advances by that amount. An interrupt-acknowledge cycle returns the counter to zero, which ties the line to the CPU's own interrupt timing. Two machine variants are supported. They differ in where the sync window sits and in whether the line count wraps on its own.

A non-maskable interrupt generator can be switched on and off by I/O writes. While it is on, the NMI line follows the sync window. If the window opens while the CPU is halted, the block asks for a small number of wait states so that the halted CPU falls back into step with the sync edge, and the counter is moved on by the same amount. A composite sync output merges the horizontal sync with an externally supplied vertical sync level.

Top module: `scanline_nmi_gen`

## Requirements
- R1: After reset, hsync, nmi, wait_req and csync (with vsync_in low) are 0, wait_count is 0 and the NMI generator is off.
- R2: Each bus cycle (cyc_valid high) moves the counter on by cyc_len. With variant_b high, a total of 207 or more has 207 subtracted. With variant_b low, the count saturates at 2^CNT_W-1.
- R3: hsync rises on the bus cycle that takes the counter from below the open point to at or above it, and falls on the bus cycle that crosses the close point. The points are 13/33 with variant_b high and 16/32 with it low.
- R4: When the window opens while the generator is on, nmi rises with hsync. nmi falls whenever the window closes.
- R5: An I/O write (cyc_valid and io_wr) with io_port = 5 turns the generator off. io_port = 6 turns it on only when variant_b is high; with variant_b low it leaves the generator off. Other port values have no effect.
- R6: If the window opens with the generator on and halt high, wait_count loads (counter plus cyc_len) minus the open point. The counter is moved on by that extra amount in the same update.
- R7: A nonzero wait_count falls by one every clock unless it is reloaded. wait_req is high exactly while wait_count is nonzero.
- R8: An interrupt-acknowledge bus cycle (cyc_valid and intack) sets the counter to 0. This takes priority over the advance.
- R9: csync equals hsync OR vsync_in.
- R10: While cyc_valid is low, the counter, hsync, nmi and the generator state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_b | input | 1 | Machine variant select (1 = variant B) |
| cyc_valid | input | 1 | A bus cycle completes this clock |
| cyc_len | input | LEN_W | Length of that bus cycle in clocks |
| intack | input | 1 | The bus cycle is an interrupt acknowledge |
| io_wr | input | 1 | The bus cycle is an I/O write |
| io_port | input | 3 | Low three address bits of the I/O write |
| halt | input | 1 | CPU halt status |
| vsync_in | input | 1 | Vertical sync level from the video logic |
| hsync | output | 1 | Horizontal sync level |
| nmi | output | 1 | Non-maskable interrupt request |
| wait_req | output | 1 | Wait state requested this clock |
| wait_count | output | LEN_W | Wait states still owed |
| csync | output | 1 | Composite sync |

## Verification
The bench uses the default parameters: a 9-bit counter and 3-bit cycle lengths, with lengths from 0 to 7. With these values the variant A saturation point, 511, is reached after about a hundred bus cycles without an acknowledge, and a single bus cycle can overshoot the open point by up to six clocks, so wait loads from 0 to 6 all occur. The variant B wrap at 207 is crossed many times per phase, including with the extra wait count added.

// File: rtl/scanline_nmi_pkg.sv
package scanline_nmi_pkg;
  localparam logic [2:0] PORT_GEN_OFF = 3'd5;
  localparam logic [2:0] PORT_GEN_ON  = 3'd6;

  typedef struct packed {
    logic opens;
    logic closes;
  } win_evt_t;
endpackage

// File: rtl/snm_hcount.sv
module snm_hcount #(
  parameter int CNT_W  = 9,
  parameter int LEN_W  = 3,
  parameter int LINE_B = 207
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_valid,
  input  logic             intack,
  input  logic             variant_b,
  input  logic [CNT_W:0]   sum,
  input  logic [LEN_W-1:0] extra,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W:0] LINE_V = (CNT_W+1)'(LINE_B);
  localparam logic [CNT_W:0] MAX_V  = (CNT_W+1)'((1 << CNT_W) - 1);

  logic [CNT_W:0]   total;
  logic [CNT_W:0]   fitted;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    total = sum + (CNT_W+1)'(extra);
    if (variant_b) begin
      fitted = (total >= LINE_V) ? (total - LINE_V) : total;
    end else begin
      fitted = (total > MAX_V) ? MAX_V : total;
    end
    cnt_en = cyc_valid;
    cnt_d  = intack ? '0 : fitted[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && intack) |=> (cnt == '0));
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> $stable(cnt));
  p_line_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && variant_b && (cnt < CNT_W'(LINE_B))) |=> (cnt < CNT_W'(LINE_B)));
endmodule

// File: rtl/snm_window.sv
module snm_window
  import scanline_nmi_pkg::*;
#(
  parameter int CNT_W   = 9,
  parameter int LEN_W   = 3,
  parameter int A_OPEN  = 16,
  parameter int A_CLOSE = 32,
  parameter int B_OPEN  = 13,
  parameter int B_CLOSE = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_valid,
  input  logic             variant_b,
  input  logic             gen_on,
  input  logic             halt,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W:0]   sum,
  output logic             hsync,
  output logic             nmi,
  output logic             align_ld,
  output logic [LEN_W-1:0] overshoot
);
  logic [CNT_W:0] open_thr;
  logic [CNT_W:0] close_thr;
  logic [CNT_W:0] cnt_x;
  logic [CNT_W:0] over_full;
  win_evt_t       evt;
  logic           hsync_d;
  logic           nmi_d;

  always_comb begin
    open_thr  = variant_b ? (CNT_W+1)'(B_OPEN)  : (CNT_W+1)'(A_OPEN);
    close_thr = variant_b ? (CNT_W+1)'(B_CLOSE) : (CNT_W+1)'(A_CLOSE);
    cnt_x     = {1'b0, cnt};
    evt.opens  = cyc_valid && (cnt_x < open_thr) && (sum >= open_thr);
    evt.closes = cyc_valid && !evt.opens && (cnt_x < close_thr) && (sum >= close_thr);
    over_full = sum - open_thr;
    overshoot = over_full[LEN_W-1:0];
    align_ld  = evt.opens && gen_on && halt;
    hsync_d = hsync;
    nmi_d   = nmi;
    if (evt.opens) begin
      hsync_d = 1'b1;
      if (gen_on) nmi_d = 1'b1;
    end else if (evt.closes) begin
      hsync_d = 1'b0;
      nmi_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync <= 1'b0;
      nmi   <= 1'b0;
    end else if (cyc_valid) begin
      hsync <= hsync_d;
      nmi   <= nmi_d;
    end
  end

  p_nmi_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> hsync);
  p_close_drops_nmi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync) |-> !nmi);
  p_hsync_on_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> ($stable(hsync) && $stable(nmi)));
endmodule

// File: rtl/snm_gen_ctrl.sv
module snm_gen_ctrl
  import scanline_nmi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_valid,
  input  logic       io_wr,
  input  logic [2:0] io_port,
  input  logic       variant_b,
  output logic       gen_on
);
  logic gen_d;
  logic gen_en;

  always_comb begin
    gen_en = cyc_valid && io_wr;
    gen_d  = gen_on;
    if (io_port == PORT_GEN_OFF) gen_d = 1'b0;
    else if (io_port == PORT_GEN_ON) gen_d = variant_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_on <= 1'b0;
    end else if (gen_en) begin
      gen_on <= gen_d;
    end
  end

  p_a_cannot_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && io_wr && (io_port == PORT_GEN_ON) && !variant_b) |=> !gen_on);
  p_off_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && io_wr && (io_port == PORT_GEN_OFF)) |=> !gen_on);
endmodule

// File: rtl/snm_wait.sv
module snm_wait #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  output logic [LEN_W-1:0] wait_count,
  output logic             wait_req
);
  logic [LEN_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (wait_count != '0);
    cnt_d  = load ? load_val : (wait_count - 1'b1);
    wait_req = (wait_count != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_count <= '0;
    end else if (cnt_en) begin
      wait_count <= cnt_d;
    end
  end

  p_countdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((wait_count != '0) && !load) |=> (wait_count == $past(wait_count) - 1'b1));
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((wait_count == '0) && !load) |=> (wait_count == '0));
endmodule

// File: rtl/scanline_nmi_gen.sv
module scanline_nmi_gen #(
  parameter int CNT_W   = 9,
  parameter int LEN_W   = 3,
  parameter int LINE_B  = 207,
  parameter int A_OPEN  = 16,
  parameter int A_CLOSE = 32,
  parameter int B_OPEN  = 13,
  parameter int B_CLOSE = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             variant_b,
  input  logic             cyc_valid,
  input  logic [LEN_W-1:0] cyc_len,
  input  logic             intack,
  input  logic             io_wr,
  input  logic [2:0]       io_port,
  input  logic             halt,
  input  logic             vsync_in,
  output logic             hsync,
  output logic             nmi,
  output logic             wait_req,
  output logic [LEN_W-1:0] wait_count,
  output logic             csync
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   sum;
  logic             gen_on;
  logic             align_ld;
  logic [LEN_W-1:0] overshoot;
  logic [LEN_W-1:0] extra;

  always_comb begin
    sum   = {1'b0, cnt} + (CNT_W+1)'(cyc_len);
    extra = align_ld ? overshoot : '0;
    csync = hsync | vsync_in;
  end

  snm_hcount #(.CNT_W(CNT_W), .LEN_W(LEN_W), .LINE_B(LINE_B)) u_hcount (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .intack(intack),
    .variant_b(variant_b), .sum(sum), .extra(extra), .cnt(cnt));

  snm_window #(.CNT_W(CNT_W), .LEN_W(LEN_W), .A_OPEN(A_OPEN), .A_CLOSE(A_CLOSE),
               .B_OPEN(B_OPEN), .B_CLOSE(B_CLOSE)) u_window (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .variant_b(variant_b),
    .gen_on(gen_on), .halt(halt), .cnt(cnt), .sum(sum), .hsync(hsync),
    .nmi(nmi), .align_ld(align_ld), .overshoot(overshoot));

  snm_gen_ctrl u_gen (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .io_wr(io_wr),
    .io_port(io_port), .variant_b(variant_b), .gen_on(gen_on));

  snm_wait #(.LEN_W(LEN_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(align_ld), .load_val(overshoot),
    .wait_count(wait_count), .wait_req(wait_req));

  p_csync_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync || vsync_in) |-> csync);
  p_wait_needs_nmi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_req) |-> nmi);
endmodule

// File: tb/scanline_nmi_gen_tb.sv
module scanline_nmi_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       variant_b = 1'b0;
  logic       cyc_valid = 1'b0;
  logic [2:0] cyc_len = '0;
  logic       intack = 1'b0;
  logic       io_wr = 1'b0;
  logic [2:0] io_port = '0;
  logic       halt = 1'b0;
  logic       vsync_in = 1'b0;
  logic       hsync, nmi, wait_req, csync;
  logic [2:0] wait_count;

  always #10 clk = ~clk;

  scanline_nmi_gen dut_i (
    .clk(clk), .rst_n(rst_n), .variant_b(variant_b), .cyc_valid(cyc_valid),
    .cyc_len(cyc_len), .intack(intack), .io_wr(io_wr), .io_port(io_port),
    .halt(halt), .vsync_in(vsync_in), .hsync(hsync), .nmi(nmi),
    .wait_req(wait_req), .wait_count(wait_count), .csync(csync));

  // behavioural reference
  int m_cnt, m_wait;
  bit m_hs, m_nmi, m_en;
  int vectors = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_wait = 0; m_hs = 0; m_nmi = 0; m_en = 0;
    end else begin
      int s, op, cl, add, tot;
      bit ld;
      ld = 0; add = 0;
      if (m_wait > 0) m_wait = m_wait - 1;
      if (cyc_valid) begin
        s  = m_cnt + int'(cyc_len);
        op = variant_b ? 13 : 16;
        cl = variant_b ? 33 : 32;
        if (m_cnt < op && s >= op) begin
          m_hs = 1;
          if (m_en) begin
            m_nmi = 1;
            if (halt) begin ld = 1; add = s - op; end
          end
        end else if (m_cnt < cl && s >= cl) begin
          m_hs = 0; m_nmi = 0;
        end
        if (ld) m_wait = add;
        tot = s + add;
        if (variant_b) begin
          if (tot >= 207) tot = tot - 207;
        end else if (tot > 511) tot = 511;
        if (intack) tot = 0;
        m_cnt = tot;
        if (io_wr) begin
          if (io_port == 3'd5) m_en = 0;
          else if (io_port == 3'd6) m_en = variant_b;
        end
      end
    end
  end

  task automatic check1(string tag, int act, int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    vectors++;
    check1("R3 hsync", hsync, m_hs);
    check1("R4 nmi", nmi, m_nmi);
    check1("R6/R7 wait_count", wait_count, m_wait);
    check1("R7 wait_req", wait_req, m_wait != 0);
    check1("R9 csync", csync, m_hs | vsync_in);
  endtask

  // one phase of random bus traffic; R2 R8 R10 are seen through hsync timing
  task automatic run_phase(bit vb, int n, int p_ack, int p_halt, int p_io, bit only_on_port);
    variant_b = vb;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      cyc_valid = ($urandom_range(0, 9) != 0);
      cyc_len   = ($urandom_range(0, 4) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(3, 6));
      intack    = ($urandom_range(1, 1000) <= p_ack);
      halt      = ($urandom_range(1, 100) <= p_halt);
      io_wr     = ($urandom_range(1, 100) <= p_io);
      io_port   = only_on_port ? 3'd6 : 3'($urandom_range(0, 7));
      vsync_in  = ($urandom_range(0, 7) == 0);
    end
  endtask

  initial begin
    #40000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    check1("R1 hsync", hsync, 0);
    check1("R1 nmi", nmi, 0);
    check1("R1 wait_req", wait_req, 0);
    check1("R1 wait_count", wait_count, 0);
    check1("R1 csync", csync, 0);
    rst_n = 1'b1;
    // R5: variant A cannot switch the generator on; R2 saturation without acks
    run_phase(1'b0, 3000, 0, 40, 20, 1'b1);
    run_phase(1'b0, 4000, 30, 40, 10, 1'b0);
    // R5/R6: variant B with the generator switched on and frequent halts
    run_phase(1'b1, 200, 0, 0, 30, 1'b1);
    run_phase(1'b1, 6000, 3, 50, 0, 1'b0);
    // mixed traffic with random ports, acks and idle cycles (R8, R10)
    run_phase(1'b1, 8000, 20, 30, 5, 1'b0);
    // R1 again after a reset in the middle of activity
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    vectors++;
    check1("R1 nmi after reset", nmi, 0);
    check1("R1 hsync after reset", hsync, 0);
    check1("R1 wait_count after reset", wait_count, 0);
    rst_n = 1'b1;
    run_phase(1'b1, 3000, 5, 50, 0, 1'b0);
    run_phase(1'b1, 100, 0, 0, 40, 1'b1);
    run_phase(1'b1, 3000, 5, 50, 0, 1'b0);
    run_phase(1'b0, 3000, 20, 30, 10, 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule